// File: doc/BRIEF.md
# Masked Configuration Header Register File

This block keeps a byte-addressable configuration space whose first 64 bytes form a standard device header. Software reaches it through one access port that carries a byte offset, a byte count from 1 to 4, write data and a write/read select. A read returns up to four consecutive bytes at once, packed little-endian. A write changes only the bits that the header layout declares writable. Read-only bits keep their value. The upper status byte works as write-one-to-clear.

Bytes at offset 64 and above are a plain scratch area, and any write there is stored as given. An access may cross from the header into that area, and each byte still follows the rule for its own offset. An access with a bad length or one that runs past the end of the space raises an error flag in the same cycle. It writes nothing and reads back zero. On reset every byte loads a default image computed from two parameters.

Top module: `cfg_space_regfile`

## Requirements
- R1: While rst_n is low at a rising clock edge, every byte i loads (i*INIT_MUL + INIT_ADD) mod 256. The defaults are INIT_MUL=37 and INIT_ADD=90.
- R2: A valid read returns the byte at acc_off in bits 7:0, the byte at acc_off+1 in bits 15:8, and so on for acc_len bytes. Lanes above acc_len read as zero. The read is combinational and returns the contents from before any write in the same cycle.
- R3: A valid write to a header byte with mask m sets the byte to (old & ~m) | (data & m). The masks are: 0x04 = 0xFF, 0x05 = 0x07, 0x0C = 0xFF, 0x10 through 0x27 = 0xFF, 0x30 = 0x01, 0x31 = 0xF8, 0x32 = 0xFF, 0x33 = 0xFF, 0x3C = 0xFF. Every other byte below 0x40 has mask 0x00, except 0x07 (see R4).
- R4: Byte 0x06 is read-only. Byte 0x07 has mask 0xF9 with write-one-to-clear semantics: new = old & ~(data & 0xF9). Writing 0 to a bit leaves that bit unchanged.
- R5: A write to any byte at offset 0x40 or above stores the written value unchanged.
- R6: A single access that spans offset 0x40 applies the R3/R4 rule to each byte below 0x40 and the R5 rule to each byte at or above it.
- R7: An enabled access is rejected when acc_len is 0, when acc_len exceeds 4, or when acc_off+acc_len exceeds SPACE_BYTES. A rejected access asserts acc_err in that same cycle, returns zero read data and leaves every byte unchanged.
- R8: acc_err is low whenever acc_en is low, whatever the other inputs are.
- R9: A write changes no byte outside acc_off .. acc_off+acc_len-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | AW (8) | Byte offset of the first byte |
| acc_len | input | 3 | Byte count |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Read data, little-endian lanes |
| acc_err | output | 1 | Rejected-access pulse |

## Verification
The bench drives all ones and then all zeros into each masked register. If a design applied the wrong mask, a read-only command or ROM bit would flip. The status byte gets a zero write and then an all-ones write. A design that treated the status byte as an ordinary masked byte would set bits instead of clearing them. A design that ignored the zero-has-no-effect rule would wipe the byte on the zero write. One write straddles offset 0x40, and a design that picked one rule for the whole access would corrupt one side of it. Rejected accesses use a zero length, a length of five and a run past the end of the space. A design that checked only some of these would store data or miss the flag.

// File: rtl/cfg_space_pkg.sv
// Shared definitions for the configuration register file.
// Assumes the 64-byte header layout; the mask table is computed, not stored.
package cfg_space_pkg;

    typedef enum logic [1:0] {
        LK_MASKED,
        LK_CLR1,
        LK_RAW
    } lane_kind_e;

    localparam int HDR_BYTES = 64;
    localparam int CLR1_IDX  = 7;

    // Writable-bit mask of byte i; bytes past the header are fully writable.
    function automatic logic [7:0] eff_mask(input int i);
        if (i >= HDR_BYTES)           return 8'hFF;
        if (i == 4 || i == 12)        return 8'hFF;
        if (i == 5)                   return 8'h07;
        if (i == CLR1_IDX)            return 8'hF9;
        if (i >= 16 && i <= 39)       return 8'hFF;
        if (i == 48)                  return 8'h01;
        if (i == 49)                  return 8'hF8;
        if (i == 50 || i == 51)       return 8'hFF;
        if (i == 60)                  return 8'hFF;
        return 8'h00;
    endfunction

    // Update rule chosen for byte i.
    function automatic lane_kind_e kind_of(input int i);
        if (i >= HDR_BYTES)  return LK_RAW;
        if (i == CLR1_IDX)   return LK_CLR1;
        return LK_MASKED;
    endfunction

    // Reset value of byte i.
    function automatic logic [7:0] init_byte(input int i, input int mul, input int add);
        return 8'((i * mul + add) % 256);
    endfunction

endpackage

// File: rtl/cfg_byte_cell.sv
// One configuration byte with a fixed update rule.
// Assumes we is only asserted for a validated write that covers this byte.
module cfg_byte_cell
    import cfg_space_pkg::*;
#(
    parameter lane_kind_e KIND = LK_MASKED,
    parameter logic [7:0] MASK = 8'h00,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wbyte,
    output logic [7:0] q
);

    logic [7:0] nxt;

    generate
        if (KIND == LK_CLR1) begin : g_clr1
            // Clear the written ones that fall inside the mask.
            assign nxt = q & ~(wbyte & MASK);
        end else begin : g_masked
            // Merge writable bits of the new data with the held read-only bits.
            assign nxt = (q & ~MASK) | (wbyte & MASK);
        end
    endgenerate

    // Byte storage with reset to its default.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= INIT;
        else if (we) q <= nxt;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R9

    generate
        if (KIND == LK_RAW) begin : g_a_raw
            AST_RAW_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (q == $past(wbyte))); // R5
        end else begin : g_a_hdr
            AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (((q ^ $past(q)) & ~MASK) == 8'h00)); // R3
        end
        if (KIND == LK_CLR1) begin : g_a_clr1
            AST_CLR1_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> ((q & ~$past(q)) == 8'h00)); // R4
        end
    endgenerate

endmodule

// File: rtl/cfg_access_dec.sv
// Validates an access and decodes which bytes it covers and from which lane.
// Assumes acc_len counts bytes; purely combinational.
module cfg_access_dec #(
    parameter int SPACE_BYTES = 256,
    parameter int AW          = $clog2(SPACE_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic [AW-1:0]            acc_off,
    input  logic [2:0]               acc_len,
    output logic                     acc_ok,
    output logic                     acc_err,
    output logic [SPACE_BYTES-1:0]   hit,
    output logic [2*SPACE_BYTES-1:0] lane_sel
);

    localparam int MAX_LEN = 4;

    logic bad;

    // Reject zero, oversize, or past-the-end accesses.
    always_comb begin
        bad = (acc_len == 3'd0) || (int'(acc_len) > MAX_LEN) ||
              (int'(acc_off) + int'(acc_len) > SPACE_BYTES);
    end

    assign acc_ok  = acc_en && !bad;
    assign acc_err = acc_en && bad;

    genvar i;
    generate
        for (i = 0; i < SPACE_BYTES; i++) begin : g_byte
            logic [AW:0] rel;
            // Distance of this byte from the first byte of the access.
            assign rel = (AW+1)'(i) - {1'b0, acc_off};
            assign hit[i] = acc_ok && ((AW+1)'(i) >= {1'b0, acc_off}) &&
                            (rel < (AW+1)'(acc_len));
            assign lane_sel[2*i +: 2] = rel[1:0];
        end
    endgenerate

    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> !acc_err); // R8
    AST_ERR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (hit == '0)); // R7
    AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) <= MAX_LEN); // R9

endmodule

// File: rtl/cfg_space_regfile.sv
// Configuration space register file: masked header, clear-on-one status byte,
// raw area above the header, combinational little-endian reads.
// Assumes one access per cycle; reads see contents before a same-cycle write.
module cfg_space_regfile
    import cfg_space_pkg::*;
#(
    parameter int SPACE_BYTES = 256,
    parameter int INIT_MUL    = 37,
    parameter int INIT_ADD    = 90,
    parameter int AW          = $clog2(SPACE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_off,
    input  logic [2:0]    acc_len,
    input  logic [31:0]   acc_wdata,
    output logic [31:0]   acc_rdata,
    output logic          acc_err
);

    localparam int LANES = 4;

    logic                     acc_ok;
    logic [SPACE_BYTES-1:0]   hit;
    logic [2*SPACE_BYTES-1:0] lane_sel;
    logic [8*SPACE_BYTES-1:0] bytes_q;

    cfg_access_dec #(.SPACE_BYTES(SPACE_BYTES), .AW(AW)) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_off  (acc_off),
        .acc_len  (acc_len),
        .acc_ok   (acc_ok),
        .acc_err  (acc_err),
        .hit      (hit),
        .lane_sel (lane_sel)
    );

    genvar i;
    generate
        for (i = 0; i < SPACE_BYTES; i++) begin : g_cell
            logic [7:0] wbyte;
            // Pick the write-data lane that lands on this byte.
            assign wbyte = acc_wdata[8*lane_sel[2*i +: 2] +: 8];
            cfg_byte_cell #(
                .KIND (kind_of(i)),
                .MASK (eff_mask(i)),
                .INIT (init_byte(i, INIT_MUL, INIT_ADD))
            ) i_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (hit[i] && acc_wr),
                .wbyte (wbyte),
                .q     (bytes_q[8*i +: 8])
            );
        end
    endgenerate

    // Gather up to four bytes little-endian; unused lanes and rejects read zero.
    always_comb begin
        acc_rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (acc_ok && (k < int'(acc_len))) begin
                acc_rdata[8*k +: 8] = bytes_q[8*(int'(acc_off) + k) +: 8];
            end
        end
    end

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> $stable(bytes_q)); // R7
    AST_ERR_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_rdata == 32'h0)); // R7

endmodule

// File: tb/test_cfg_space_regfile.sv
module test_cfg_space_regfile;

    localparam int SPACE = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_off = '0;
    logic [2:0]  acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [SPACE];
    logic [31:0] s_rdata;
    logic        s_err;

    always #10 clk = ~clk;

    cfg_space_regfile i_cfg_space_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_off   (acc_off),
        .acc_len   (acc_len),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .acc_err   (acc_err)
    );

    // Writable mask per the requirements.
    function automatic logic [7:0] bmask(input int i);
        case (i)
            4, 12, 50, 51, 60: return 8'hFF;
            5:  return 8'h07;
            7:  return 8'hF9;
            48: return 8'h01;
            49: return 8'hF8;
            default: begin
                if (i >= 64) return 8'hFF;
                if (i >= 16 && i < 40) return 8'hFF;
                return 8'h00;
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_model();
        for (int i = 0; i < SPACE; i++) exp_mem[i] = 8'((i * 37 + 90) % 256);
    endtask

    // One access cycle; samples combinational outputs before the edge.
    task automatic access(input int off, input int len, input bit wr, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_off = 8'(off); acc_len = 3'(len); acc_wdata = d;
        #2;
        s_rdata = acc_rdata;
        s_err   = acc_err;
        @(posedge clk);
        #1;
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic do_write(input int off, input int len, input logic [31:0] d);
        access(off, len, 1'b1, d);
        for (int k = 0; k < len; k++) begin
            logic [7:0] m;
            logic [7:0] w;
            m = bmask(off + k);
            w = d[8*k +: 8];
            if (off + k == 7) exp_mem[off+k] = exp_mem[off+k] & ~(w & m);
            else exp_mem[off+k] = (exp_mem[off+k] & ~m) | (w & m);
        end
    endtask

    task automatic check_read(input int off, input int len, input string tag);
        logic [31:0] e;
        e = '0;
        for (int k = 0; k < len; k++) e[8*k +: 8] = exp_mem[off+k];
        access(off, len, 1'b0, 32'h0);
        chk(tag, s_rdata, e);
        chk({tag, " err"}, {31'h0, s_err}, 32'h0);
    endtask

    task automatic t_reset();
        check_read(8'h00, 4, "R1 reset 0x00");
        check_read(8'h04, 4, "R1 reset 0x04");
        check_read(8'hFC, 4, "R1 reset 0xFC");
        check_read(8'h81, 1, "R2 single-byte upper lanes zero");
        check_read(8'h3D, 3, "R2 three-byte read");
    endtask

    task automatic t_cmd();
        do_write(8'h04, 2, 32'h0000FFFF);
        check_read(8'h04, 2, "R3 command ones");
        do_write(8'h04, 2, 32'h00000000);
        check_read(8'h04, 2, "R3 command zeros");
        do_write(8'h00, 4, 32'hFFFFFFFF);
        check_read(8'h00, 4, "R3 read-only id bytes");
        do_write(8'h0C, 4, 32'h12345678);
        check_read(8'h0C, 4, "R3 cache line byte");
    endtask

    task automatic t_status();
        do_write(8'h06, 2, 32'h00000000);
        check_read(8'h06, 2, "R4 zero write no effect");
        do_write(8'h06, 2, 32'h0000FFFF);
        check_read(8'h06, 2, "R4 clear on one");
    endtask

    task automatic t_rom();
        do_write(8'h30, 4, 32'hFFFFFFFF);
        check_read(8'h30, 4, "R3 rom ones");
        do_write(8'h30, 4, 32'h00000000);
        check_read(8'h30, 4, "R3 rom zeros");
        do_write(8'h24, 4, 32'hCAFEF00D);
        check_read(8'h24, 4, "R3 bar bytes");
    endtask

    task automatic t_raw();
        do_write(8'h80, 4, 32'hDEADBEEF);
        check_read(8'h80, 4, "R5 raw word");
        do_write(8'h41, 3, 32'h00A1B2C3);
        check_read(8'h40, 4, "R5 raw partial");
    endtask

    task automatic t_span();
        do_write(8'h3E, 4, 32'hA5A5A5A5);
        check_read(8'h3C, 4, "R6 span header side");
        check_read(8'h40, 2, "R6 span raw side");
    endtask

    task automatic t_partial();
        do_write(8'h11, 1, 32'hFFFFFF77);
        check_read(8'h10, 4, "R9 neighbours kept");
    endtask

    task automatic t_err();
        access(8'h10, 5, 1'b1, 32'h11111111);
        chk("R7 len5 err", {31'h0, s_err}, 32'h1);
        access(8'h10, 0, 1'b1, 32'h22222222);
        chk("R7 len0 err", {31'h0, s_err}, 32'h1);
        access(8'hFE, 4, 1'b1, 32'h33333333);
        chk("R7 past end err", {31'h0, s_err}, 32'h1);
        access(8'hFD, 4, 1'b0, 32'h0);
        chk("R7 reject read zero", s_rdata, 32'h0);
        check_read(8'h10, 4, "R7 no change low");
        check_read(8'hFC, 4, "R7 no change high");
        access(8'hFC, 4, 1'b0, 32'h0);
        chk("R7 exact end ok", {31'h0, s_err}, 32'h0);
    endtask

    task automatic t_noen();
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b1; acc_off = 8'hFF; acc_len = 3'd7; acc_wdata = 32'hFFFFFFFF;
        #2;
        chk("R8 no err without enable", {31'h0, acc_err}, 32'h0);
        @(posedge clk);
        #1;
        acc_wr = 1'b0;
        check_read(8'hFC, 4, "R8 idle no write");
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        load_model();
        check_read(8'h04, 4, "R1 re-reset command");
        check_read(8'h80, 4, "R1 re-reset raw");
    endtask

    initial begin
        load_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_status();
        t_rom();
        t_raw();
        t_span();
        t_partial();
        t_err();
        t_noen();
        t_rereset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule